// File: doc/BRIEF.md
# Endian-Selectable FIFO Byte-Lane Port

This block connects two 32-bit word queues to a narrow local-bus data port. A width-mode input selects a port of 8 or 16 bits. Local reads take the word at the head of the receive queue and return it one lane per access. The queue is popped once the last lane of the word has been read. Local writes gather lanes into a 32-bit word, and the finished word is pushed into the transmit queue when its last lane arrives.

An order input picks the lane sequence. With the input low, the lowest lane is moved first. With it high, the highest lane is moved first. Each direction has its own lane pointer. A one-cycle channel-disable pulse sends that pointer back to the first lane. Width or order may only change while both pointers are at the first lane, so software pulses both disables before it changes either one.

Two active-low request outputs let an external two-channel DMA controller move data without CPU help. The read request is active while the receive queue holds a word. The write request is active while the transmit queue has room. The queues themselves are not part of the block.

Top module: `fifo_lane_port`

## Requirements
- R1: With `mode_wide`=0 and `msb_first`=0, four reads return bytes 0,1,2,3 of the head word, zero-extended on `bus_rdata[15:8]`. For word 00C0FFEEh the reads return EE, FF, C0, 00.
- R2: With `mode_wide`=1 and `msb_first`=0, two reads return bits [15:0] and then bits [31:16] of the head word. For 00C0FFEEh the reads return FFEE, 00C0.
- R3: With `msb_first`=1 the order is reversed in both widths. For 00C0FFEEh, 8-bit reads return 00, C0, FF, EE and 16-bit reads return 00C0, FFEE.
- R4: `rx_pop` is raised only in the cycle of a read of the final lane with the receive queue non-empty. Earlier lanes leave the queue untouched.
- R5: Writes fill lanes in the same order as R1–R3, using `bus_wdata[7:0]` in 8-bit mode. One cycle after the final lane is written, `tx_push` is high for one cycle with the gathered word on `tx_data`.
- R6: A read while `rx_empty` is high returns 0 on the next cycle and does not move the read pointer.
- R7: A final-lane write while `tx_full` is high pushes nothing and sets `tx_ovf`. `tx_ovf` stays high until reset. The write pointer still returns to the first lane.
- R8: A one-cycle pulse on `rx_dis` or `tx_dis` returns that direction's pointer to the first lane. The pulse takes priority over an access in the same cycle, and that access is ignored.
- R9: `rx_req_n` is low exactly while `rx_empty` is low. `tx_req_n` is low exactly while `tx_full` is low.
- R10: After reset, `bus_rdata` is 0, `tx_push` is 0, `tx_ovf` is 0 and both pointers are at the first lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wide | input | 1 | 0: 8-bit port, 1: 16-bit port |
| msb_first | input | 1 | 0: lowest lane first, 1: highest lane first |
| bus_rd | input | 1 | Data-port read strobe, one cycle per access |
| bus_wr | input | 1 | Data-port write strobe, one cycle per access |
| bus_wdata | input | 16 | Write lane (bits [7:0] in 8-bit mode) |
| bus_rdata | output | 16 | Registered read lane |
| rx_dis | input | 1 | Receive channel disable pulse, clears the read pointer |
| tx_dis | input | 1 | Transmit channel disable pulse, clears the write pointer |
| rx_empty | input | 1 | Receive queue empty |
| rx_data | input | 32 | Receive queue head word (show-ahead) |
| rx_pop | output | 1 | Pop the receive queue |
| tx_full | input | 1 | Transmit queue full |
| tx_push | output | 1 | Push into the transmit queue |
| tx_data | output | 32 | Word to push |
| rx_req_n | output | 1 | Read DMA request, active low |
| tx_req_n | output | 1 | Write DMA request, active low |
| tx_ovf | output | 1 | Sticky transmit overflow flag |

## Verification
A read lane appears on `bus_rdata` one cycle after its strobe, so the monitor compares it on the falling edge that follows the clock edge that latched the strobe. `rx_pop` acts at the same rising edge as the final-lane read. The bench's receive queue therefore updates its status one edge later, and the request and queue checks wait a full cycle after each read. A pushed word appears on `tx_push` one cycle after the final-lane write, and the queue model consumes it one edge after that. The bench waits three cycles before it relies on `tx_full` or on an absence of pushes.

// File: rtl/lane_port_pkg.sv
package lane_port_pkg;

    localparam int unsigned WORD_W_DEF = 32;
    localparam int unsigned LANE_W_DEF = 8;

    // Physical lane slot for a given sequence position.
    function automatic int unsigned lane_slot(
        input int unsigned pos,
        input int unsigned count,
        input logic        msb_first
    );
        return msb_first ? (count - 1 - pos) : pos;
    endfunction

endpackage

// File: rtl/lane_ptr.sv
module lane_ptr #(
    parameter int unsigned NL = 4,
    localparam int unsigned PW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [PW-1:0] last_idx,
    output logic [PW-1:0] ptr,
    output logic          at_last
);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    assign ptr     = st_q.ptr;
    assign at_last = (st_q.ptr == last_idx);

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ptr = '0;
        end else if (adv) begin
            st_d.ptr = at_last ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_clear_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr == '0));

    assert_wrap_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && at_last && !clr) |=> (ptr == '0));

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(ptr));

endmodule

// File: rtl/rx_lane_unpack.sv
module rx_lane_unpack
    import lane_port_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    parameter int unsigned LANE_W = LANE_W_DEF,
    localparam int unsigned NL = WORD_W / LANE_W,
    localparam int unsigned NW = NL / 2,
    localparam int unsigned BW = 2 * LANE_W,
    localparam int unsigned PW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wide,
    input  logic              msb_first,
    input  logic              bus_rd,
    input  logic              rx_dis,
    input  logic              rx_empty,
    input  logic [WORD_W-1:0] rx_data,
    output logic              rx_pop,
    output logic [BW-1:0]     bus_rdata
);

    typedef struct packed {
        logic [BW-1:0] rdata;
    } rx_state_t;

    rx_state_t st_d, st_q;

    logic [PW-1:0] ptr;
    logic          at_last;
    logic [PW-1:0] last_idx;
    logic          rd_take;
    int unsigned   slot;
    int unsigned   shamt;
    logic [BW-1:0] lane_val;

    assign last_idx = mode_wide ? PW'(NW - 1) : PW'(NL - 1);
    assign rd_take  = bus_rd && !rx_empty && !rx_dis;
    assign rx_pop   = rd_take && at_last;

    lane_ptr #(.NL(NL)) u_rd_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_dis),
        .adv      (rd_take),
        .last_idx (last_idx),
        .ptr      (ptr),
        .at_last  (at_last)
    );

    always_comb begin
        slot  = lane_slot(int'(ptr), mode_wide ? NW : NL, msb_first);
        shamt = slot * (mode_wide ? BW : LANE_W);
        if (mode_wide) begin
            lane_val = BW'(rx_data >> shamt);
        end else begin
            lane_val = {{(BW - LANE_W){1'b0}}, LANE_W'(rx_data >> shamt)};
        end
    end

    always_comb begin
        st_d = st_q;
        if (bus_rd && !rx_dis) begin
            st_d.rdata = rx_empty ? '0 : lane_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

    assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && rx_empty && !rx_dis) |=> (bus_rdata == '0));

    assert_pop_needs_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (!rx_empty && bus_rd));

    assert_narrow_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mode_wide && !rx_dis) |=> (bus_rdata[BW-1:LANE_W] == '0));

endmodule

// File: rtl/tx_lane_pack.sv
module tx_lane_pack
    import lane_port_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    parameter int unsigned LANE_W = LANE_W_DEF,
    localparam int unsigned NL = WORD_W / LANE_W,
    localparam int unsigned NW = NL / 2,
    localparam int unsigned BW = 2 * LANE_W,
    localparam int unsigned PW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wide,
    input  logic              msb_first,
    input  logic              bus_wr,
    input  logic [BW-1:0]     bus_wdata,
    input  logic              tx_dis,
    input  logic              tx_full,
    output logic              tx_push,
    output logic [WORD_W-1:0] tx_data,
    output logic              tx_ovf
);

    typedef struct packed {
        logic [WORD_W-1:0] gather;
        logic              push;
        logic [WORD_W-1:0] data;
        logic              ovf;
    } tx_state_t;

    tx_state_t st_d, st_q;

    logic [PW-1:0]     ptr;
    logic              at_last;
    logic [PW-1:0]     last_idx;
    logic              wr_take;
    int unsigned       slot;
    int unsigned       shamt;
    logic [WORD_W-1:0] lane_mask;
    logic [WORD_W-1:0] lane_bits;
    logic [WORD_W-1:0] merged;

    assign last_idx = mode_wide ? PW'(NW - 1) : PW'(NL - 1);
    assign wr_take  = bus_wr && !tx_dis;

    lane_ptr #(.NL(NL)) u_wr_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tx_dis),
        .adv      (wr_take),
        .last_idx (last_idx),
        .ptr      (ptr),
        .at_last  (at_last)
    );

    always_comb begin
        slot  = lane_slot(int'(ptr), mode_wide ? NW : NL, msb_first);
        shamt = slot * (mode_wide ? BW : LANE_W);
        if (mode_wide) begin
            lane_mask = WORD_W'({BW{1'b1}}) << shamt;
            lane_bits = WORD_W'(bus_wdata) << shamt;
        end else begin
            lane_mask = WORD_W'({LANE_W{1'b1}}) << shamt;
            lane_bits = WORD_W'(bus_wdata[LANE_W-1:0]) << shamt;
        end
        merged = (st_q.gather & ~lane_mask) | lane_bits;
    end

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        if (tx_dis) begin
            st_d.gather = '0;
        end else if (wr_take) begin
            st_d.gather = merged;
            if (at_last) begin
                if (tx_full) begin
                    st_d.ovf = 1'b1;
                end else begin
                    st_d.push = 1'b1;
                    st_d.data = merged;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_push = st_q.push;
    assign tx_data = st_q.data;
    assign tx_ovf  = st_q.ovf;

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |=> tx_ovf);

    assert_drop_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && at_last && tx_full) |=> (!tx_push && tx_ovf));

    assert_push_after_final_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && at_last && !tx_full) |=> tx_push);

    assert_push_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |=> !tx_push);

endmodule

// File: rtl/fifo_lane_port.sv
module fifo_lane_port
    import lane_port_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    parameter int unsigned LANE_W = LANE_W_DEF,
    localparam int unsigned BW = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wide,
    input  logic              msb_first,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BW-1:0]     bus_wdata,
    output logic [BW-1:0]     bus_rdata,
    input  logic              rx_dis,
    input  logic              tx_dis,
    input  logic              rx_empty,
    input  logic [WORD_W-1:0] rx_data,
    output logic              rx_pop,
    input  logic              tx_full,
    output logic              tx_push,
    output logic [WORD_W-1:0] tx_data,
    output logic              rx_req_n,
    output logic              tx_req_n,
    output logic              tx_ovf
);

    rx_lane_unpack #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wide (mode_wide),
        .msb_first (msb_first),
        .bus_rd    (bus_rd),
        .rx_dis    (rx_dis),
        .rx_empty  (rx_empty),
        .rx_data   (rx_data),
        .rx_pop    (rx_pop),
        .bus_rdata (bus_rdata)
    );

    tx_lane_pack #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wide (mode_wide),
        .msb_first (msb_first),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .tx_dis    (tx_dis),
        .tx_full   (tx_full),
        .tx_push   (tx_push),
        .tx_data   (tx_data),
        .tx_ovf    (tx_ovf)
    );

    assign rx_req_n = rx_empty;
    assign tx_req_n = tx_full;

    assert_no_pop_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> !rx_req_n);

endmodule

// File: tb/fifo_lane_port_bench.sv
module fifo_lane_port_bench;

    localparam int TXDEP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wide = 1'b0;
    logic        msb_first = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rx_dis = 1'b0;
    logic        tx_dis = 1'b0;
    logic        rx_empty = 1'b1;
    logic [31:0] rx_data = '0;
    logic        rx_pop;
    logic        tx_full = 1'b0;
    logic        tx_push;
    logic [31:0] tx_data;
    logic        rx_req_n;
    logic        tx_req_n;
    logic        tx_ovf;

    always #5 clk = ~clk;

    fifo_lane_port u_fifo_lane_port (
        .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .msb_first(msb_first),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_dis(rx_dis), .tx_dis(tx_dis), .rx_empty(rx_empty), .rx_data(rx_data),
        .rx_pop(rx_pop), .tx_full(tx_full), .tx_push(tx_push), .tx_data(tx_data),
        .rx_req_n(rx_req_n), .tx_req_n(tx_req_n), .tx_ovf(tx_ovf)
    );

    // queue models and scoreboards
    logic [31:0] rx_q[$];
    logic [31:0] tx_q[$];
    logic [15:0] exp_rd[$];
    string       tag_rd[$];
    logic [31:0] exp_tx[$];
    string       tag_tx[$];

    int main_vec = 0, main_bad = 0;
    int rd_vec = 0, rd_bad = 0;
    int tx_vec = 0, tx_bad = 0;

    logic [31:0] load_word = '0;
    int          load_cnt = 0, load_seen = 0;
    int          drain_cnt = 0, drain_seen = 0;
    logic        rd_seen = 1'b0;

    // receive and transmit queue models
    always @(posedge clk) begin
        if (rx_pop && rx_q.size() > 0) void'(rx_q.pop_front());
        if (load_cnt != load_seen) begin
            rx_q.push_back(load_word);
            load_seen = load_cnt;
        end
        if (tx_push) begin
            tx_vec++;
            if (exp_tx.size() == 0) begin
                tx_bad++;
                $display("FAIL %s unexpected push act=%h exp=none", "R7", tx_data);
            end else begin
                automatic logic [31:0] e = exp_tx.pop_front();
                automatic string t = tag_tx.pop_front();
                if (tx_data !== e) begin
                    tx_bad++;
                    $display("FAIL %s tx word act=%h exp=%h", t, tx_data, e);
                end
            end
            if (tx_q.size() < TXDEP) tx_q.push_back(tx_data);
        end
        if (drain_cnt != drain_seen) begin
            tx_q.delete();
            drain_seen = drain_cnt;
        end
        rx_empty <= (rx_q.size() == 0);
        rx_data  <= (rx_q.size() > 0) ? rx_q[0] : 32'h0;
        tx_full  <= (tx_q.size() >= TXDEP);
        rd_seen  <= bus_rd;
    end

    // read monitor
    always @(negedge clk) begin
        if (rd_seen && exp_rd.size() > 0) begin
            automatic logic [15:0] e = exp_rd.pop_front();
            automatic string t = tag_rd.pop_front();
            rd_vec++;
            if (bus_rdata !== e) begin
                rd_bad++;
                $display("FAIL %s read lane act=%h exp=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic chk(input logic ok, input string t, input logic [31:0] act, input logic [31:0] e);
        main_vec++;
        if (!ok) begin
            main_bad++;
            $display("FAIL %s act=%h exp=%h", t, act, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [31:0] w);
        @(negedge clk);
        load_word = w;
        load_cnt++;
        @(negedge clk);
    endtask

    task automatic rd(input logic [15:0] e, input string t);
        @(negedge clk);
        bus_rd = 1'b1;
        exp_rd.push_back(e);
        tag_rd.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_tx(input logic [31:0] w, input string t);
        exp_tx.push_back(w);
        tag_tx.push_back(t);
    endtask

    task automatic drain();
        @(negedge clk);
        drain_cnt++;
        @(negedge clk);
    endtask

    task automatic pulse_dis(input logic r, input logic w);
        @(negedge clk);
        rx_dis = r;
        tx_dis = w;
        @(negedge clk);
        rx_dis = 1'b0;
        tx_dis = 1'b0;
    endtask

    task automatic set_mode(input logic wide, input logic msb);
        pulse_dis(1'b1, 1'b1);
        mode_wide = wide;
        msb_first = msb;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==",
                 main_vec + rd_vec + tx_vec, main_bad + rd_bad + tx_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        main_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R10 reset state
        chk(bus_rdata == 16'h0, "R10 rdata", 32'(bus_rdata), 0);
        chk(tx_push == 1'b0, "R10 push", 32'(tx_push), 0);
        chk(tx_ovf == 1'b0, "R10 ovf", 32'(tx_ovf), 0);
        chk(rx_req_n == 1'b1, "R9 rx_req idle", 32'(rx_req_n), 1);
        chk(tx_req_n == 1'b0, "R9 tx_req idle", 32'(tx_req_n), 0);

        // R1 byte reads, low first
        set_mode(1'b0, 1'b0);
        load(32'h00C0FFEE);
        chk(rx_req_n == 1'b0, "R9 rx_req with word", 32'(rx_req_n), 0);
        rd(16'h00EE, "R1");
        rd(16'h00FF, "R1");
        rd(16'h00C0, "R4");
        idle(1);
        chk(rx_req_n == 1'b0, "R4 no pop before final lane", 32'(rx_req_n), 0);
        rd(16'h0000, "R1");
        idle(1);
        chk(rx_req_n == 1'b1, "R4 popped after final lane", 32'(rx_req_n), 1);

        // R6 empty read returns zero, pointer held
        rd(16'h0000, "R6 empty");
        load(32'h11223344);
        rd(16'h0044, "R6");
        rd(16'h0033, "R6");
        rd(16'h0022, "R6");
        rd(16'h0011, "R6");

        // R3 byte reads, high first
        set_mode(1'b0, 1'b1);
        load(32'h00C0FFEE);
        rd(16'h0000, "R3");
        rd(16'h00C0, "R3");
        rd(16'h00FF, "R3");
        rd(16'h00EE, "R3");

        // R2 wide reads, low first
        set_mode(1'b1, 1'b0);
        load(32'h00C0FFEE);
        rd(16'hFFEE, "R2");
        rd(16'h00C0, "R2");

        // R3 wide reads, high first
        set_mode(1'b1, 1'b1);
        load(32'h00C0FFEE);
        rd(16'h00C0, "R3 wide");
        rd(16'hFFEE, "R3 wide");

        // R8 read pointer cleared mid-word
        set_mode(1'b0, 1'b0);
        load(32'hA5B6C7D8);
        rd(16'h00D8, "R8");
        pulse_dis(1'b1, 1'b0);
        rd(16'h00D8, "R8");
        rd(16'h00C7, "R8");
        rd(16'h00B6, "R8");
        rd(16'h00A5, "R8");
        idle(1);
        chk(rx_req_n == 1'b1, "R8 word consumed once", 32'(rx_req_n), 1);

        // R5 write assembly in all four modes
        expect_tx(32'h00C0FFEE, "R5 byte low");
        wr(16'h00EE); wr(16'h00FF); wr(16'h00C0); wr(16'h0000);
        idle(3); drain();
        set_mode(1'b0, 1'b1);
        expect_tx(32'h00C0FFEE, "R5 byte high");
        wr(16'hAB00); wr(16'h00C0); wr(16'h00FF); wr(16'h00EE);
        idle(3); drain();
        set_mode(1'b1, 1'b0);
        expect_tx(32'h00C0FFEE, "R5 wide low");
        wr(16'hFFEE); wr(16'h00C0);
        idle(3); drain();
        set_mode(1'b1, 1'b1);
        expect_tx(32'h00C0FFEE, "R5 wide high");
        wr(16'h00C0); wr(16'hFFEE);
        idle(3); drain();

        // R8 write pointer cleared mid-word
        set_mode(1'b0, 1'b0);
        wr(16'h0011); wr(16'h0022);
        pulse_dis(1'b0, 1'b1);
        expect_tx(32'h11223344, "R8 tx");
        wr(16'h0044); wr(16'h0033); wr(16'h0022); wr(16'h0011);
        idle(3); drain();
        chk(exp_tx.size() == 0, "R8 tx pushed", exp_tx.size(), 0);

        // R7 overflow
        for (int i = 0; i < TXDEP; i++) begin
            expect_tx(32'h01020304 + 32'(i), "R7 fill");
            wr(16'h0004 + 16'(i)); wr(16'h0003); wr(16'h0002); wr(16'h0001);
        end
        idle(3);
        chk(tx_req_n == 1'b1, "R9 tx_req full", 32'(tx_req_n), 1);
        chk(tx_ovf == 1'b0, "R7 no ovf yet", 32'(tx_ovf), 0);
        wr(16'h00AA); wr(16'h00BB); wr(16'h00CC); wr(16'h00DD);
        idle(3);
        chk(tx_ovf == 1'b1, "R7 ovf set", 32'(tx_ovf), 1);
        drain();
        idle(1);
        chk(tx_req_n == 1'b0, "R9 tx_req room", 32'(tx_req_n), 0);
        expect_tx(32'h89ABCDEF, "R7 after drop");
        wr(16'h00EF); wr(16'h00CD); wr(16'h00AB); wr(16'h0089);
        idle(3);
        chk(tx_ovf == 1'b1, "R7 ovf sticky", 32'(tx_ovf), 1);
        chk(exp_tx.size() == 0, "R5 all pushes seen", exp_tx.size(), 0);
        chk(exp_rd.size() == 0, "R1 all reads seen", exp_rd.size(), 0);
        idle(2);
        finish_run();
    end

endmodule